// File: doc/BRIEF.md
# Display Window Framebuffer Address Generator

This block sits after a display timing generator. Each cycle it takes the coordinates of the current pixel and a valid qualifier. It decides whether that pixel lies inside a programmable rectangle. For a pixel inside the rectangle it issues a framebuffer read request with the byte address of that pixel. Pixels are stored as unpacked 24-bit colour, so each one occupies one 32-bit word.

A registered in-window flag follows the request by one clock. This lets the fetched pixel data line up with the active pixel. Data returned from memory passes through an optional exchange of its two 16-bit halves before it leaves the block.

The window corners arrive as packed words. The window control word carries three fields: an enable bit, a pixel-format code and a half-word swap bit. If an address would fall at or beyond the end of the buffer, the block does not issue a read. It raises an error strobe instead.

Top module: `win_addr_gen`

## Requirements
- R1: A pixel is in the window when pix_valid is high and its x lies between the left and right corner x values and its y lies between the top and bottom corner y values, both corners inclusive. Each corner word holds x in bits [21:11] and y in bits [10:0]; win_tl is the top-left corner and win_br the bottom-right corner.
- R2: For an in-window pixel, rd_addr = fb_start + ((y - top) * (right - left + 1) + (x - left)) * 4, so every issued address is 4-byte aligned.
- R3: rd_req, rd_addr and addr_err show the result for the pixel sampled at the previous rising edge. in_win is high exactly one cycle after that, so it follows the request stage by one clock.
- R4: When bit 0 of win_ctrl (window enable) is 0, rd_req, addr_err and in_win all stay low.
- R5: The window works only when win_ctrl bits [5:2] equal 4'b1011 (unpacked 24-bit RGB, one 32-bit word per pixel). Any other code makes the block behave as if it were disabled.
- R6: When the computed address of an in-window pixel is greater than or equal to fb_end, addr_err pulses in place of rd_req. rd_req is never high together with addr_err, and in_win still marks the pixel.
- R7: When win_ctrl bit 15 is 1, pix_data equals fetch_data with its upper and lower 16-bit halves exchanged. When bit 15 is 0, pix_data equals fetch_data. The path is combinational.
- R8: While rst_n is low, rd_req, rd_addr, addr_err and in_win are all zero.
- R9: A cycle with pix_valid low produces no request, no error and no in-window flag, whatever the coordinates are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_valid | input | 1 | Current coordinates belong to an active pixel |
| pix_x | input | 11 | Current pixel column |
| pix_y | input | 11 | Current pixel row |
| win_tl | input | 22 | Top-left corner, x in [21:11], y in [10:0] |
| win_br | input | 22 | Bottom-right corner (inclusive), same packing |
| fb_start | input | 32 | Byte address of the first window pixel |
| fb_end | input | 32 | Byte address one past the buffer |
| win_ctrl | input | 16 | Bit 0 enable, bits [5:2] format, bit 15 half swap |
| fetch_data | input | 32 | Word returned from the framebuffer |
| rd_req | output | 1 | Read strobe for rd_addr |
| rd_addr | output | 32 | Framebuffer byte address |
| addr_err | output | 1 | Address reached or passed fb_end |
| in_win | output | 1 | Pixel inside window, one clock after rd_req |
| pix_data | output | 32 | fetch_data, half-swapped when enabled |

## Verification
The assertions compare the registered request stage with fb_end as it stood one cycle earlier. They therefore assume that the buffer limit and window registers change only between frames and never between a pixel and its request. They also assume left ≤ right and top ≤ bottom, and that start plus the window size fits within 32 bits. The stimulus follows these rules: it reprograms every register only between sweeps of a small frame, it always uses ordered corners, and it keeps the buffer near a low base address. Inside each sweep, pix_valid is gated in a fixed pattern so that gaps appear within window rows.

// File: rtl/wag_pkg.sv
package wag_pkg;
  localparam int CTRL_W     = 16;
  localparam int EN_BIT     = 0;
  localparam int FMT_LSB    = 2;
  localparam int FMT_W      = 4;
  localparam int SWAP_BIT   = 15;
  localparam int BYTE_SHIFT = 2;
  localparam logic [FMT_W-1:0] FMT_UNPACKED24 = 4'b1011;
endpackage

// File: rtl/win_hit.sv
module win_hit #(
  parameter int CW = 11
) (
  input  logic          valid,
  input  logic          win_on,
  input  logic [CW-1:0] x,
  input  logic [CW-1:0] y,
  input  logic [2*CW-1:0] tl,
  input  logic [2*CW-1:0] br,
  output logic          hit,
  output logic [CW-1:0] dx,
  output logic [CW-1:0] dy,
  output logic [CW:0]   span_w
);
  function automatic logic in_span(input logic [CW-1:0] v,
                                   input logic [CW-1:0] lo,
                                   input logic [CW-1:0] hi);
    return (v >= lo) && (v <= hi);
  endfunction

  logic [CW-1:0] left, top, right, bottom;
  assign left   = tl[2*CW-1:CW];
  assign top    = tl[CW-1:0];
  assign right  = br[2*CW-1:CW];
  assign bottom = br[CW-1:0];

  assign hit    = valid && win_on && in_span(x, left, right) && in_span(y, top, bottom);
  assign dx     = x - left;
  assign dy     = y - top;
  assign span_w = {1'b0, right} - {1'b0, left} + {{CW{1'b0}}, 1'b1};
endmodule

// File: rtl/addr_calc.sv
module addr_calc
  import wag_pkg::*;
#(
  parameter int CW = 11,
  parameter int AW = 32
) (
  input  logic [CW-1:0] dx,
  input  logic [CW-1:0] dy,
  input  logic [CW:0]   span_w,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] limit,
  output logic [AW-1:0] addr,
  output logic          beyond
);
  function automatic logic [AW-1:0] word_addr(input logic [AW-1:0] b,
                                              input logic [CW-1:0] row,
                                              input logic [CW-1:0] col,
                                              input logic [CW:0]   w);
    logic [AW-1:0] lin;
    lin = AW'(row) * AW'(w) + AW'(col);
    return b + (lin << BYTE_SHIFT);
  endfunction

  assign addr   = word_addr(base, dy, dx, span_w);
  assign beyond = (addr >= limit);
endmodule

// File: rtl/word_swap.sv
module word_swap #(
  parameter int DW = 32
) (
  input  logic          swap_en,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout
);
  localparam int HW = DW / 2;

  generate
    if ((DW % 2) == 0) begin : g_even
      function automatic logic [DW-1:0] halves_swapped(input logic [DW-1:0] v);
        return {v[HW-1:0], v[DW-1:HW]};
      endfunction
      assign dout = swap_en ? halves_swapped(din) : din;
    end else begin : g_odd
      logic swap_unused;
      assign swap_unused = swap_en;
      assign dout = din;
    end
  endgenerate
endmodule

// File: rtl/win_addr_gen.sv
module win_addr_gen
  import wag_pkg::*;
#(
  parameter int CW = 11,
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pix_valid,
  input  logic [CW-1:0]     pix_x,
  input  logic [CW-1:0]     pix_y,
  input  logic [2*CW-1:0]   win_tl,
  input  logic [2*CW-1:0]   win_br,
  input  logic [AW-1:0]     fb_start,
  input  logic [AW-1:0]     fb_end,
  input  logic [CTRL_W-1:0] win_ctrl,
  input  logic [DW-1:0]     fetch_data,
  output logic              rd_req,
  output logic [AW-1:0]     rd_addr,
  output logic              addr_err,
  output logic              in_win,
  output logic [DW-1:0]     pix_data
);
  // decoded control fields
  logic             win_on;
  logic             swap_on;
  logic [FMT_W-1:0] fmt_code;
  logic             ctrl_unused;
  assign fmt_code    = win_ctrl[FMT_LSB +: FMT_W];
  assign win_on      = win_ctrl[EN_BIT] && (fmt_code == FMT_UNPACKED24);
  assign swap_on     = win_ctrl[SWAP_BIT];
  assign ctrl_unused = &{1'b0, win_ctrl[CTRL_W-2:FMT_LSB+FMT_W], win_ctrl[1]};

  // stage 0: combinational decision
  logic          hit_s0;
  logic [CW-1:0] dx_s0, dy_s0;
  logic [CW:0]   span_s0;
  logic [AW-1:0] addr_s0;
  logic          beyond_s0;

  win_hit #(.CW(CW)) u_hit (
    .valid (pix_valid),
    .win_on(win_on),
    .x     (pix_x),
    .y     (pix_y),
    .tl    (win_tl),
    .br    (win_br),
    .hit   (hit_s0),
    .dx    (dx_s0),
    .dy    (dy_s0),
    .span_w(span_s0)
  );

  addr_calc #(.CW(CW), .AW(AW)) u_addr (
    .dx    (dx_s0),
    .dy    (dy_s0),
    .span_w(span_s0),
    .base  (fb_start),
    .limit (fb_end),
    .addr  (addr_s0),
    .beyond(beyond_s0)
  );

  // named events for checking
  logic req_ev_s0, err_ev_s0;
  assign req_ev_s0 = hit_s0 && !beyond_s0;
  assign err_ev_s0 = hit_s0 && beyond_s0;

  // stage 1: request; stage 2: in-window flag
  logic hit_s1;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_req   <= 1'b0;
      addr_err <= 1'b0;
      rd_addr  <= '0;
      hit_s1   <= 1'b0;
      in_win   <= 1'b0;
    end else begin
      rd_req   <= req_ev_s0;
      addr_err <= err_ev_s0;
      rd_addr  <= hit_s0 ? addr_s0 : '0;
      hit_s1   <= hit_s0;
      in_win   <= hit_s1;
    end
  end

  word_swap #(.DW(DW)) u_swap (
    .swap_en(swap_on),
    .din    (fetch_data),
    .dout   (pix_data)
  );

  // R4, R5: a window that is off or in another format issues nothing
  p_quiet_when_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!win_on) |-> (!rd_req && !addr_err));

  // R6: a request and an error never coincide
  p_req_err_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req && addr_err));

  // R6: every issued request stays below the buffer end
  p_below_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> (rd_addr < $past(fb_end)));

  // R2: word-aligned addresses
  p_addr_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> (rd_addr[1:0] == 2'b00));

  // R3: in-window flag trails the request stage by one clock
  p_flag_after_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_win |-> $past(rd_req || addr_err));

  // R9: an invalid pixel yields no request next cycle
  p_idle_invalid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!pix_valid) |-> (!rd_req && !addr_err));
endmodule

// File: tb/win_addr_gen_tb.sv
module win_addr_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pix_valid = 1'b0;
  logic [10:0] pix_x = '0, pix_y = '0;
  logic [21:0] win_tl = '0, win_br = '0;
  logic [31:0] fb_start = '0, fb_end = '0;
  logic [15:0] win_ctrl = '0;
  logic [31:0] fetch_data = '0;
  logic        rd_req, addr_err, in_win;
  logic [31:0] rd_addr, pix_data;

  always #4 clk = ~clk;

  win_addr_gen dut_i (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_x(pix_x), .pix_y(pix_y),
    .win_tl(win_tl), .win_br(win_br), .fb_start(fb_start), .fb_end(fb_end),
    .win_ctrl(win_ctrl), .fetch_data(fetch_data), .rd_req(rd_req), .rd_addr(rd_addr),
    .addr_err(addr_err), .in_win(in_win), .pix_data(pix_data)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  // reference model state
  bit  e_req = 0, e_err = 0, e_in = 0, prev_hit = 0;
  longint e_addr = 0;
  bit  hit_q[$];
  string mtag = "R1";

  task automatic check(string tag, longint act, longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // behavioural model of one pixel
  task automatic model(bit pv, int x, int y);
    int l, t, r, b;
    bit on, hit;
    longint a;
    l = int'(win_tl[21:11]); t = int'(win_tl[10:0]);
    r = int'(win_br[21:11]); b = int'(win_br[10:0]);
    on  = win_ctrl[0] && (win_ctrl[5:2] == 4'hB);
    hit = pv && on && x >= l && x <= r && y >= t && y <= b;
    a = longint'(fb_start) + 4 * ((y - t) * (r - l + 1) + (x - l));
    hit_q.push_back(hit);
    e_in = (hit_q.size() > 2) ? hit_q.pop_front() : 1'b0;
    e_req  = hit && (a < longint'(fb_end));
    e_err  = hit && (a >= longint'(fb_end));
    e_addr = hit ? a : 0;
  endtask

  task automatic step(bit pv, int x, int y);
    string rt;
    logic [31:0] d;
    @(negedge clk);
    rt = pix_valid ? mtag : "R9";
    check({rt, " rd_req"}, rd_req, e_req);
    check("R6 addr_err", addr_err, e_err);
    if (e_req || e_err) check("R2 rd_addr", rd_addr, e_addr);
    check("R3 in_win", in_win, hit_q.size() > 1 ? hit_q[0] : 1'b0);
    pix_valid = pv; pix_x = 11'(x); pix_y = 11'(y);
    d = $urandom;
    fetch_data = d;
    #1;
    check("R7 pix_data", pix_data, win_ctrl[15] ? {d[15:0], d[31:16]} : d);
    model(pv, x, y);
  endtask

  task automatic sweep(int l, int t, int r, int b, int start, int endoff,
                       logic [15:0] ctrl, string tag);
    win_tl = {11'(l), 11'(t)}; win_br = {11'(r), 11'(b)};
    fb_start = 32'(start); fb_end = 32'(start + endoff);
    win_ctrl = ctrl; mtag = tag;
    for (int y = 0; y < 8; y++)
      for (int x = 0; x < 16; x++)
        step(((x + 3 * y) % 7) != 5, x, y);
    // flush the pipeline with idle pixels
    for (int k = 0; k < 3; k++) step(1'b0, 0, 0);
  endtask

  initial begin
    repeat (3) begin
      @(negedge clk);
      check("R8 rd_req", rd_req, 0);
      check("R8 rd_addr", rd_addr, 0);
      check("R8 addr_err", addr_err, 0);
      check("R8 in_win", in_win, 0);
    end
    rst_n = 1'b1;
    sweep(3, 2, 12, 6, 32'h1000, 10 * 5 * 4, 16'h002D, "R1");
    sweep(3, 2, 12, 6, 32'h2000, 10 * 5 * 4, 16'h802D, "R1");
    sweep(3, 2, 12, 6, 32'h3000, 20 * 4, 16'h002D, "R6");
    sweep(3, 2, 12, 6, 32'h4000, 10 * 5 * 4, 16'h802C, "R4");
    sweep(3, 2, 12, 6, 32'h5000, 10 * 5 * 4, 16'h0015, "R5");
    sweep(0, 0, 0, 0, 32'h6000, 4, 16'h002D, "R1");
    sweep(15, 7, 15, 7, 32'h7000, 4, 16'h002D, "R1");
    sweep(0, 0, 15, 7, 32'h8000, 16 * 8 * 4, 16'h802D, "R1");
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end
endmodule